// File: doc/BRIEF.md
# NAND Segment Hamming Code Generator

This block watches the byte stream on a NAND flash data port and folds every transferred byte into a Hamming-style code. The code is three bytes long and covers one segment of 256 bytes. Because it only observes the stream, the same logic serves page reads and page writes. On a write, software reads the code and stores it in the spare area. On a read, software compares the code against the stored copy and does the error location and correction itself.

Software starts a segment by writing a control register that enables accumulation, clears the accumulators and picks inverted output. It then moves the 256 data bytes through the port. The code can be read one byte at a time. It can also be read as a single 32-bit word, in which the controller's status byte sits in the low byte and the three code bytes sit above it.

Top module: `nand_ecc_gen`

## Requirements
- R1: While enabled and before the segment is full, each cycle with `dp_valid` high updates the code and advances a byte position counter. The counter starts at 0 after a clear and serves as the line index (0 to 255) of that byte.
- R2: Line parity is a 16-bit word. For each index bit k (0..7), bit 2k+1 is the XOR of the byte parities (XOR of the 8 data bits) of all bytes whose index has bit k set. Bit 2k is the same XOR over bytes whose index has bit k clear. Address 1 returns word bits 7:0 and address 2 returns word bits 15:8.
- R3: The column byte (address 3) carries six column parities in bits 7:2, ordered from bit 7 down as {P4, P4', P2, P2', P1, P1'}. Pn is the XOR, over all counted bytes, of the data bits whose bit position has weight n set. Pn' is the same XOR over the positions with weight n clear. Bits 1:0 always read 1.
- R4: The control register is at address 5, with bit 0 enable, bit 1 clear and bit 2 invert. A write with bit 1 set zeroes the counter and all accumulators in the cycle of the write. A data byte presented in that same cycle is not counted. The clear bit reads back as 0, so address 5 reads {5'b0, invert, 1'b0, enable}.
- R5: After 256 bytes have been counted, further data bytes change nothing until the next clear.
- R6: While enable is 0, data bytes change neither the code nor the counter.
- R7: With invert set, the line bytes and column bits 7:2 are read inverted, so an all-0xFF segment reads 0xFF, 0xFF, 0xFF. With invert clear they are read as accumulated.
- R8: Address 0 returns a 32-bit word: `status_byte` in bits 7:0, line-low in 15:8, line-high in 23:16 and column in 31:24. Reads at addresses 1, 2, 3 and 5 return the byte in bits 7:0 with the upper bits 0. Addresses 4, 6 and 7 read 0.
- R9: After reset, enable and invert are 0 and all accumulators are 0, so address 0 reads {0x03, 0x00, 0x00, status}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_valid | input | 1 | A data byte moves through the port this cycle |
| dp_byte | input | 8 | Data byte on the port |
| status_byte | input | 8 | Controller status, packed into the word read |
| reg_addr | input | 3 | Register offset (0 word, 1 line-low, 2 line-high, 3 column, 5 control) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |

## Verification
An erased segment of all 0xFF is run with inversion on; it must yield 0xFF in every code byte, which confirms the inversion and the fixed column bits. Two distinct 256-byte patterns, a scrambled ramp and an index-dependent mix, are compared against a bench model with inversion off and on. Any mistake in the index-bit pairing or in the column masks shows up there. Short partial segments exercise the mid-segment code value. Extra bytes past the end of a segment, bytes sent while disabled, and a byte that lands in the same cycle as a clear each test one of the gating rules.

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen #(
  parameter int SEG_BYTES = 256,
  parameter int DW        = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dp_valid,
  input  logic [7:0]  dp_byte,
  input  logic [7:0]  status_byte,
  input  logic [2:0]  reg_addr,
  input  logic        reg_we,
  input  logic [7:0]  reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int IW  = $clog2(SEG_BYTES);
  localparam int CW  = $clog2(DW);
  localparam int LW  = 2 * IW;
  localparam int CPW = 2 * CW;
  localparam logic [IW:0] FULL = SEG_BYTES[IW:0];

  logic          en_q, inv_q;
  logic [IW:0]   cnt;
  logic [LW-1:0] lp, lp_upd;
  logic [CPW-1:0] cp, cp_upd;

  wire ctl_wr = reg_we && (reg_addr == 3'd5);
  wire clr    = ctl_wr && reg_wdata[1];
  wire take   = dp_valid && en_q && (cnt < FULL);
  wire bpar   = ^dp_byte;

  genvar k, g, b;
  generate
    for (k = 0; k < IW; k++) begin : g_line
      assign lp_upd[2*k+1] = bpar &  cnt[k];
      assign lp_upd[2*k]   = bpar & ~cnt[k];
    end
    for (g = 0; g < CW; g++) begin : g_col
      logic [DW-1:0] msk;
      for (b = 0; b < DW; b++) begin : g_m
        assign msk[b] = ((b >> g) & 1) == 1;
      end
      assign cp_upd[2*g+1] = ^(dp_byte &  msk);
      assign cp_upd[2*g]   = ^(dp_byte & ~msk);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      inv_q <= 1'b0;
      cnt   <= '0;
      lp    <= '0;
      cp    <= '0;
    end else begin
      if (ctl_wr) begin
        en_q  <= reg_wdata[0];
        inv_q <= reg_wdata[2];
      end
      if (clr) begin
        cnt <= '0;
        lp  <= '0;
        cp  <= '0;
      end else if (take) begin
        cnt <= cnt + 1'b1;
        lp  <= lp ^ lp_upd;
        cp  <= cp ^ cp_upd;
      end
    end
  end

  wire [LW-1:0]  lp_o = inv_q ? ~lp : lp;
  wire [CPW-1:0] cp_o = inv_q ? ~cp : cp;
  wire [15:0]    line = 16'(lp_o);
  wire [7:0]     col  = {cp_o, {(8-CPW){1'b1}}};

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {col, line[15:8], line[7:0], status_byte};
      3'd1:    reg_rdata = {24'd0, line[7:0]};
      3'd2:    reg_rdata = {24'd0, line[15:8]};
      3'd3:    reg_rdata = {24'd0, col};
      3'd5:    reg_rdata = {29'd0, inv_q, 1'b0, en_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module nand_ecc_chk #(
  parameter int IW  = 8,
  parameter int LW  = 16,
  parameter int CPW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dp_valid,
  input logic [7:0]    status_byte,
  input logic [2:0]    reg_addr,
  input logic          reg_we,
  input logic [7:0]    reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          en_q,
  input logic [IW:0]   cnt,
  input logic [LW-1:0] lp,
  input logic [CPW-1:0] cp
);
  localparam logic [IW:0] FULL = (IW+1)'(1) << IW;
  wire clr_w = reg_we && reg_addr == 3'd5 && reg_wdata[1];

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (cnt == '0 && lp == '0 && cp == '0)); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && en_q && cnt < FULL && !clr_w) |=> cnt == $past(cnt) + 1'b1); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && !clr_w) |=> (cnt == FULL && $stable(lp) && $stable(cp))); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !clr_w) |=> ($stable(cnt) && $stable(lp) && $stable(cp))); // R6
  AST_COL_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd3) |-> (reg_rdata[1:0] == 2'b11 && reg_rdata[31:8] == 24'd0)); // R3
  AST_WORD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0) |-> reg_rdata[7:0] == status_byte); // R8
endmodule

bind nand_ecc_gen nand_ecc_chk #(.IW(IW), .LW(LW), .CPW(CPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dp_valid(dp_valid), .status_byte(status_byte),
  .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .en_q(en_q), .cnt(cnt), .lp(lp), .cp(cp)
);

// File: tb/sim_nand_ecc_gen.sv
module sim_nand_ecc_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        dp_valid = 0;
  logic [7:0]  dp_byte = 0;
  logic [7:0]  status_byte = 8'hA5;
  logic [2:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [7:0]  reg_wdata = 0;
  logic [31:0] reg_rdata;

  int errors = 0, checks = 0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  nand_ecc_gen u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected {col, hi, lo} over the first n bytes of mem
  function automatic logic [23:0] model(input int n, input bit inv);
    logic [15:0] l = 0;
    logic [5:0]  c = 0;
    for (int i = 0; i < n; i++) begin
      logic p = ^mem[i];
      for (int k = 0; k < 8; k++)
        if ((i >> k) & 1) l[2*k+1] ^= p; else l[2*k] ^= p;
      for (int bi = 0; bi < 8; bi++)
        for (int g = 0; g < 3; g++)
          if ((bi >> g) & 1) c[2*g+1] ^= mem[i][bi]; else c[2*g] ^= mem[i][bi];
    end
    if (inv) begin l = ~l; c = ~c; end
    return {c, 2'b11, l[15:8], l[7:0]};
  endfunction

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk);
    reg_addr = 3'd5; reg_we = 1; reg_wdata = v;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dp_valid = 1; dp_byte = mem[i];
    end
    @(negedge clk);
    dp_valid = 0;
  endtask

  task automatic check_code(input string tag, input logic [23:0] e);
    reg_addr = 3'd1; #1 check({tag, " lo"}, reg_rdata, {24'd0, e[7:0]});
    reg_addr = 3'd2; #1 check({tag, " hi"}, reg_rdata, {24'd0, e[15:8]});
    reg_addr = 3'd3; #1 check({tag, " col"}, reg_rdata, {24'd0, e[23:16]});
    reg_addr = 3'd0; #1 check({tag, " word R8"}, reg_rdata, {e[23:16], e[15:8], e[7:0], status_byte});
  endtask

  task automatic t_reset;
    check_code("R9 reset", 24'h030000);
    reg_addr = 3'd5; #1 check("R9 ctl reset", reg_rdata, 0);
    reg_addr = 3'd4; #1 check("R8 unused addr", reg_rdata, 0);
  endtask

  task automatic t_erased;
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    ctl_write(8'h07);
    reg_addr = 3'd5; #1 check("R4 clear reads 0", reg_rdata, 32'h5);
    send(256);
    check_code("R7 erased", 24'hFFFFFF);
  endtask

  task automatic t_pattern(input int sel, input bit inv);
    for (int i = 0; i < 256; i++)
      mem[i] = (sel == 0) ? 8'(i ^ 8'h5A) : 8'((i * 37) ^ (i >> 3));
    ctl_write(inv ? 8'h07 : 8'h03);
    send(256);
    check_code(inv ? "R2 R3 R7 pattern inv" : "R1 R2 R3 pattern raw", model(256, inv));
  endtask

  task automatic t_partial;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 1);
    ctl_write(8'h03);
    send(11);
    check_code("R1 partial", model(11, 0));
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i + 7);
    ctl_write(8'h03);
    send(256);
    for (int i = 0; i < 6; i++) mem[i] = 8'h01 << (i % 8);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); dp_valid = 1; dp_byte = mem[i];
    end
    @(negedge clk); dp_valid = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i + 7);
    check_code("R5 past end", model(256, 0));
  endtask

  task automatic t_disabled;
    ctl_write(8'h06);
    for (int i = 0; i < 20; i++) mem[i] = 8'h01;
    send(20);
    check_code("R6 disabled", 24'hFFFFFF);
    reg_addr = 3'd5; #1 check("R4 ctl readback", reg_rdata, 32'h4);
  endtask

  task automatic t_collision;
    mem[0] = 8'h80;
    ctl_write(8'h03);
    mem[0] = 8'h01; send(1);
    @(negedge clk);
    reg_addr = 3'd5; reg_we = 1; reg_wdata = 8'h03;
    dp_valid = 1; dp_byte = 8'h80;
    @(negedge clk);
    reg_we = 0; dp_valid = 1; dp_byte = 8'h07;
    @(negedge clk);
    dp_valid = 0;
    mem[0] = 8'h07;
    check_code("R4 clear collision", model(1, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_erased();
    t_pattern(0, 0);
    t_pattern(1, 0);
    t_pattern(0, 1);
    t_pattern(1, 1);
    t_partial();
    t_overflow();
    t_disabled();
    t_collision();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule